// File: doc/BRIEF.md
# Serial Bit Buffer Readout Port

This block sits between a bit-level data decoder and a host controller. Decoded bits arrive one at a time on a write strobe, with a flag that marks a detected sync word. The block keeps them in a first-in, first-out bit store. The host drains the store over a three-wire link: a ready line that is high while any unread bit is held, a data line that shows the oldest unread bit, and a readout clock.

The readout clock can run in two ways. In slave mode the host drives the clock and the block steps to the next bit on each falling edge of that clock. The clock is seen through a synchronizer. In master mode the block drives the clock itself, with programmable high and low widths, and the host captures data on each falling edge. The host selects the mode with a level input, and it may change the mode in the middle of a stream. The read position is shared by both modes, so no bit is lost or repeated across a change.

A synchronous clear input empties the store, drops the ready line and disarms the store. After that, incoming bits are thrown away until a bit arrives flagged as sync. That bit and every later bit are stored, whether or not they carry the flag. If the store is full, new bits are dropped and a sticky overflow flag is raised.

Top module: `sbb_readout_port`

## Requirements
- R1: `rdy` is high exactly when at least one unread bit is held. A single stored bit raises it on the next clock. `rd_data` reads 0 while the store is empty.
- R2: A one-cycle `clr` pulse empties the store, clears `ovf` and drives `rdy` low from the next clock. An active-low `rst_n` does the same and also resets every other register.
- R3: After reset or `clr`, bits written without `sync_hit` are discarded. The first bit written with `sync_hit`=1 is stored, and so is every later bit, regardless of `sync_hit`.
- R4: In slave mode (`mode_slave`=1), `rd_data` stays constant while `host_clk` is high. It moves to the next bit only after a falling edge of `host_clk`, and the change lands 3 clock cycles after that edge, well inside 0.75 µs. This covers the drop of `rdy` after the last bit.
- R5: Bits are read out in the order they were stored.
- R6: In master mode (`mode_slave`=0), `clk_oe` is 1 and `clk_out` pulses high for exactly HALF_CYC cycles. Each pulse follows at least HALF_CYC low cycles and starts only while `rdy` is 1. `rd_data` holds the bit for a pulse until one cycle after that pulse's falling edge.
- R7: When the mode changes in either direction between bits, the next bit presented is the one after the last bit consumed. There is no gap and no repeat.
- R8: When a bit is written while all DEPTH entries are occupied, the bit is dropped and `ovf` goes to 1. `ovf` stays at 1 until `clr` or reset.
- R9: In slave mode `clk_out` stays low. In master mode, edges on `host_clk` do not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear used on channel change |
| wr_vld | input | 1 | Write strobe for one decoded bit |
| wr_bit | input | 1 | Decoded bit value |
| sync_hit | input | 1 | Sync detected with this bit |
| host_clk | input | 1 | Readout clock from the host (slave mode) |
| mode_slave | input | 1 | 1 = host drives the clock, 0 = block drives it |
| rdy | output | 1 | At least one unread bit held |
| rd_data | output | 1 | Oldest unread bit |
| clk_out | output | 1 | Readout clock driven by the block (master mode) |
| clk_oe | output | 1 | Enable for the clk_out driver |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Stored streams are drained by host clocking alone, by the internal generator alone, and by sequences that switch mode in both directions part way through a stream. A slip of one bit in the read position at a mode change shows up as a shifted sequence. Bursts of random length, in random data order, check that ready tracks a single bit and falls at the right point after the final falling edge. A burst that overfills the store, followed by a full read, shows whether the dropped bits were the newest ones. Writes made before the first sync, both after reset and after a clear, show whether the gate reopens only on the flagged bit.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  typedef enum logic {PH_LOW, PH_HIGH} gen_phase_e;

  // one-cycle falling edge between a delayed and a current sample
  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // number of unread entries from wrapping pointers (one extra wrap bit)
  function automatic int unsigned fill_level(input int unsigned wp,
                                             input int unsigned rp,
                                             input int unsigned depth);
    return (wp + 2 * depth - rp) % (2 * depth);
  endfunction
endpackage

// File: rtl/sbb_sync.sv
module sbb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= '0;
        else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sbb_store.sv
module sbb_store #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_vld,
  input  logic                     wr_bit,
  input  logic                     sync_hit,
  input  logic                     adv,
  output logic                     rd_bit,
  output logic                     rdy,
  output logic                     ovf,
  output logic                     armed,
  output logic [$clog2(DEPTH):0]   occ,
  output logic                     store_ev,
  output logic                     drop_ev
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0] wp, rp;
  logic        mem [DEPTH];
  logic        arm_now, full, empty, pop_ev;

  assign occ     = AW'(0) == 0 ? (AW+1)'(sbb_pkg::fill_level(int'(wp), int'(rp), DEPTH)) : '0;
  assign full    = (occ == (AW+1)'(DEPTH));
  assign empty   = (wp == rp);
  assign arm_now = armed | (wr_vld & sync_hit);

  assign store_ev = wr_vld & arm_now & ~full & ~clr;
  assign drop_ev  = wr_vld & arm_now &  full & ~clr;
  assign pop_ev   = adv & ~empty & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      armed <= 1'b0;
      ovf   <= 1'b0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      armed <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      armed <= arm_now;
      if (store_ev) wp  <= wp + 1'b1;
      if (pop_ev)   rp  <= rp + 1'b1;
      if (drop_ev)  ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (store_ev) mem[wp[AW-1:0]] <= wr_bit;

  assign rdy    = ~empty;
  assign rd_bit = empty ? 1'b0 : mem[rp[AW-1:0]];
endmodule

// File: rtl/sbb_reader.sv
module sbb_reader #(
  parameter int HALF_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic slave_s,
  input  logic hclk_s,
  input  logic rdy,
  output logic adv,
  output logic slave_fall,
  output logic clk_out,
  output logic clk_oe
);
  import sbb_pkg::*;
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic            hclk_prev;
  gen_phase_e      phase;
  logic [CW-1:0]   cnt;
  logic            m_adv;

  // slave path: edge detect on the synchronized host clock
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hclk_prev <= 1'b0;
    else        hclk_prev <= hclk_s;

  assign slave_fall = slave_s & fell(hclk_prev, hclk_s);

  // master path: a started high phase always completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOW;
      cnt   <= '0;
      m_adv <= 1'b0;
    end else if (clr) begin
      phase <= PH_LOW;
      cnt   <= '0;
      m_adv <= 1'b0;
    end else begin
      m_adv <= 1'b0;
      if (phase == PH_LOW) begin
        if (cnt != LAST)           cnt <= cnt + 1'b1;
        else if (!slave_s && rdy) begin
          phase <= PH_HIGH;
          cnt   <= '0;
        end
      end else begin
        if (cnt == LAST) begin
          phase <= PH_LOW;
          cnt   <= '0;
          m_adv <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign clk_out = (phase == PH_HIGH);
  assign clk_oe  = ~slave_s;
  assign adv     = slave_fall | m_adv;
endmodule

// File: rtl/sbb_readout_port.sv
module sbb_readout_port #(
  parameter int DEPTH       = 16,
  parameter int HALF_CYC    = 38,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_vld,
  input  logic wr_bit,
  input  logic sync_hit,
  input  logic host_clk,
  input  logic mode_slave,
  output logic rdy,
  output logic rd_data,
  output logic clk_out,
  output logic clk_oe,
  output logic ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]  sync_q;
  logic        slave_s, hclk_s;
  logic        adv, slave_fall, armed, store_ev, drop_ev;
  logic [AW:0] occ;

  sbb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({mode_slave, host_clk}), .q(sync_q)
  );
  assign slave_s = sync_q[1];
  assign hclk_s  = sync_q[0];

  sbb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_vld(wr_vld), .wr_bit(wr_bit), .sync_hit(sync_hit), .adv(adv),
    .rd_bit(rd_data), .rdy(rdy), .ovf(ovf), .armed(armed), .occ(occ),
    .store_ev(store_ev), .drop_ev(drop_ev)
  );

  sbb_reader #(.HALF_CYC(HALF_CYC)) u_reader (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .slave_s(slave_s), .hclk_s(hclk_s), .rdy(rdy),
    .adv(adv), .slave_fall(slave_fall), .clk_out(clk_out), .clk_oe(clk_oe)
  );
endmodule

// File: rtl/sbb_readout_port_chk.sv
module sbb_readout_port_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clr,
  input logic                   wr_vld,
  input logic                   rdy,
  input logic                   ovf,
  input logic                   clk_out,
  input logic                   slave_s,
  input logic                   armed,
  input logic                   adv,
  input logic                   store_ev,
  input logic [$clog2(DEPTH):0] occ
);
  localparam int OW = $clog2(DEPTH) + 1;

  assert_store_sets_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (store_ev && !clr) |=> rdy);

  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rdy && !ovf && occ == '0));

  assert_unarmed_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (occ == '0 && !rdy));

  assert_master_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(rdy));

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && armed && occ == OW'(DEPTH) && !clr) |=>
      (ovf && (occ == ($past(adv) ? OW'(DEPTH - 1) : OW'(DEPTH)))));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);

  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_s && !clk_out) |=> !clk_out);
endmodule

bind sbb_readout_port sbb_readout_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_vld(wr_vld), .rdy(rdy), .ovf(ovf),
  .clk_out(clk_out), .slave_s(slave_s), .armed(armed), .adv(adv),
  .store_ev(store_ev), .occ(occ)
);

// File: tb/sbb_readout_port_test.sv
module sbb_readout_port_test;
  localparam int DEPTH = 16;
  localparam int HALF  = 38;

  logic clk = 0, rst_n = 0, clr = 0, wr_vld = 0, wr_bit = 0, sync_hit = 0;
  logic host_clk = 0, mode_slave = 1;
  logic rdy, rd_data, clk_out, clk_oe, ovf;

  int checks = 0, fails = 0;
  bit q[$];

  sbb_readout_port #(.DEPTH(DEPTH), .HALF_CYC(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_vld(wr_vld), .wr_bit(wr_bit),
    .sync_hit(sync_hit), .host_clk(host_clk), .mode_slave(mode_slave),
    .rdy(rdy), .rd_data(rd_data), .clk_out(clk_out), .clk_oe(clk_oe), .ovf(ovf)
  );

  always #10 clk = ~clk;

  function automatic bit exp_ready();
    return q.size() != 0;
  endfunction

  function automatic bit keeps(int held);
    return held < DEPTH;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic wr(bit b, bit s, bit model);
    @(negedge clk);
    wr_vld = 1; wr_bit = b; sync_hit = s;
    @(negedge clk);
    wr_vld = 0; sync_hit = 0;
    if (model && keeps(q.size())) q.push_back(b);
  endtask

  task automatic hread();
    bit e;
    @(negedge clk);
    e = q.pop_front();
    chk(rd_data == e, "R5", rd_data, e);
    host_clk = 1;
    repeat (20) @(negedge clk);
    chk(rd_data == e, "R4", rd_data, e);
    repeat (20) @(negedge clk);
    host_clk = 0;
    repeat (4) @(negedge clk);
    chk(rdy == exp_ready(), "R4", rdy, exp_ready());
    repeat (36) @(negedge clk);
  endtask

  task automatic cap_master(int n);
    int got = 0, hi = 0;
    bit seen = 0, e;
    logic prev = clk_out;
    while (got < n) begin
      @(negedge clk);
      if (clk_out) begin
        if (!prev) begin hi = 0; seen = 1; end
        hi++;
      end else if (prev) begin
        e = q.pop_front();
        chk(rd_data == e, "R7", rd_data, e);
        if (seen) chk(hi == HALF, "R6", hi, HALF);
        got++;
      end
      prev = clk_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!rdy, "R1", rdy, 0);
    chk(!rd_data, "R1", rd_data, 0);
    chk(!ovf && !clk_out && !clk_oe, "R2", {ovf, clk_out, clk_oe}, 0);

    // gate before first sync (R3)
    repeat (5) wr(1'b1, 1'b0, 1'b0);
    chk(!rdy, "R3", rdy, 0);
    wr(1'b1, 1'b1, 1'b1);
    chk(rdy, "R1", rdy, 1);
    repeat (9) wr(1'($urandom), 1'($urandom), 1'b1);
    while (q.size() != 0) hread();

    // random bursts in slave mode (R5)
    for (int r = 0; r < 3; r++) begin
      int n = 1 + ($urandom % DEPTH);
      for (int i = 0; i < n; i++) wr(1'($urandom), 1'b0, 1'b1);
      chk(rdy == exp_ready(), "R1", rdy, 1);
      while (q.size() != 0) hread();
    end

    // overflow (R8)
    for (int i = 0; i < DEPTH + 3; i++) wr(1'($urandom), 1'b0, 1'b1);
    chk(ovf, "R8", ovf, 1);
    while (q.size() != 0) hread();
    chk(ovf, "R8", ovf, 1);

    // clear (R2, R3)
    wr(1'b1, 1'b0, 1'b1);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    q.delete();
    chk(!rdy && !ovf, "R2", {rdy, ovf}, 0);
    repeat (3) wr(1'b1, 1'b0, 1'b0);
    chk(!rdy, "R3", rdy, 0);

    // master mode (R6, R9)
    mode_slave = 0;
    repeat (4) @(negedge clk);
    chk(clk_oe, "R6", clk_oe, 1);
    repeat (3) begin
      host_clk = 1; repeat (5) @(negedge clk);
      host_clk = 0; repeat (5) @(negedge clk);
    end
    chk(!rdy && !clk_out, "R9", {rdy, clk_out}, 0);
    wr(1'b0, 1'b1, 1'b1);
    repeat (7) wr(1'($urandom), 1'b0, 1'b1);
    cap_master(8);
    repeat (4) @(negedge clk);
    chk(!rdy, "R6", rdy, 0);

    // mode changes mid-stream (R7)
    mode_slave = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 12; i++) wr(1'($urandom), 1'b0, 1'b1);
    repeat (4) hread();
    mode_slave = 0;
    cap_master(4);
    mode_slave = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clk_out) chk(0, "R9", 1, 0);
    end
    chk(rdy, "R7", rdy, 1);
    while (q.size() != 0) hread();
    chk(!rdy, "R7", rdy, 0);

    summary();
  end
endmodule